// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the bus-facing slave logic of a 2 KB serial memory holding eight banks of 256 bytes. It receives the serial clock and data lines as plain samples, moves them into the system clock domain, detects start and stop conditions, and drives only an open-drain pull-down enable for the data line. A command opens with a control byte whose top nibble is the fixed code 1010, followed by a 3-bit bank field and a direction bit. The bank field supplies the top three bits of the 11-bit memory address, so no device address comes from pins.

Write traffic sets the low eight pointer bits from the second byte and then hands each further byte to an external page buffer over a valid/ready stream. A one-cycle commit pulse on STOP tells that buffer to start its internal write cycle. While the buffer reports busy, the block acknowledges no byte at all, so a master can poll for completion by repeating a write control byte. Reads fetch bytes from a synchronous memory port with one cycle of latency. Current-address, random and sequential reads are all supported, and the pointer is shared across commands.

Back-pressure rule on the write stream: a beat stays valid, with address and data unchanged, until `wr_ready` is seen high on a rising clock edge. A data byte that completes while the previous beat is still waiting is neither acknowledged nor offered, and the block then ignores the bus until the next START or STOP.

Top module: `tw_mem_slave`

## Requirements
- R1: After reset, `sda_oe`, `wr_valid`, `wr_commit` and `rd_en` are all low.
- R2: After a START, a control byte with top nibble 1010 is acknowledged by pulling SDA low for the whole ninth clock.
- R3: A control byte with any other top nibble gets no ACK. Until the next START or STOP, every later byte also gets no ACK and no write beat is offered.
- R4: While `busy_i` is high, no byte is acknowledged, including a valid control byte. Once `busy_i` is low, the same control byte is acknowledged.
- R5: In a write, control bits [3:1] (bank) become address bits [10:8] and the second byte becomes bits [7:0]. The third byte is offered on the write stream at that address and is acknowledged.
- R6: Further data bytes in one write increment only address bits [3:0], wrapping within the 16-byte page. For example, 0x0FE, 0x0FF, 0x0F0.
- R7: A STOP that ends a write in which at least one data byte was offered raises `wr_commit` for exactly one cycle. A write carrying only an address raises no commit.
- R8: `wr_valid` with `wr_addr`/`wr_data` holds steady until accepted. A byte that completes while a beat is pending gets no ACK and is never offered.
- R9: A random read (write of the address, repeated START, read control byte) returns the byte stored at the addressed location, MSB first.
- R10: A current-address read returns the byte at the last accessed address plus one, with the bank taken from the read control byte.
- R11: A master ACK after a read byte makes the block send the next address. The 11-bit pointer wraps from 0x7FF to 0x000.
- R12: After a master NACK on a read byte, SDA stays released until the next START or STOP.
- R13: `sda_oe` changes only while the synchronized SCL is low, so the block's output never forms a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line sample |
| sda_i | input | 1 | Serial data line sample (wired bus value) |
| sda_oe | output | 1 | High pulls the data line low |
| busy_i | input | 1 | Internal write cycle in progress |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Page buffer accepts the beat |
| wr_addr | output | 11 | Write beat byte address |
| wr_data | output | 8 | Write beat data |
| wr_commit | output | 1 | One-cycle pulse: start the write cycle |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | 11 | Memory read address |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |

## Verification
The STOP that closes a write can fall in the same period as a write beat that is still waiting for `wr_ready`, so the commit pulse and the stream handshake overlap. The bench holds `wr_ready` low across a two-byte write, which makes the second byte collide with the pending first beat. It then issues STOP and raises `wr_ready` only afterwards. This case is judged by several results together: the second byte gets a NACK, exactly one commit appears, the first beat arrives with its original address and data, and the neighbouring location still reads back its old value.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_WADDR,
    ST_WDATA,
    ST_RDATA,
    ST_DROP
  } tw_state_e;

  localparam logic [3:0] CTRL_CODE = 4'b1010;
  localparam int unsigned BYTE_BITS = 8;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_prev, sda_prev;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_ff[SYNC_STAGES-1];
  assign sda_s = sda_ff[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/tw_addr_ptr.sv
module tw_addr_ptr #(
  parameter int unsigned ADDR_W    = 11,
  parameter int unsigned BANK_W    = 3,
  parameter int unsigned PAGE_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_we,
  input  logic [BANK_W-1:0] bank_val,
  input  logic              low_we,
  input  logic [ADDR_W-BANK_W-1:0] low_val,
  input  logic              inc_page,
  input  logic              inc_full,
  output logic [ADDR_W-1:0] ptr_q
);
  localparam int unsigned LOW_W = ADDR_W - BANK_W;

  logic [ADDR_W-1:0] base;

  always_comb begin
    base = ptr_q;
    if (bank_we) base = {bank_val, ptr_q[LOW_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (low_we) begin
      ptr_q[LOW_W-1:0] <= low_val;
    end else if (inc_page) begin
      ptr_q[PAGE_BITS-1:0] <= ptr_q[PAGE_BITS-1:0] + 1'b1;
    end else if (inc_full) begin
      ptr_q <= base + 1'b1;
    end else if (bank_we) begin
      ptr_q <= base;
    end
  end

  // R6
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_page && !low_we |=> ptr_q[ADDR_W-1:PAGE_BITS] == $past(ptr_q[ADDR_W-1:PAGE_BITS]));

  // R11
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_full && !bank_we && !low_we && !inc_page |=> ptr_q == ADDR_W'($past(ptr_q) + 1'b1));
endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave #(
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned BANK_W      = 3,
  parameter int unsigned PAGE_BITS   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              busy_i,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data
);
  import tw_pkg::*;

  localparam int unsigned LOW_W = ADDR_W - BANK_W;
  localparam logic [3:0]  ACK_BIT = 4'(BYTE_BITS);
  localparam logic [3:0]  END_BIT = 4'(BYTE_BITS + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  tw_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  logic              bank_we_q, low_we_q, inc_page_q, inc_full_q;
  logic [BANK_W-1:0] bank_v_q;
  logic [LOW_W-1:0]  low_v_q;
  logic [ADDR_W-1:0] ptr;

  tw_addr_ptr #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .PAGE_BITS(PAGE_BITS)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .bank_we(bank_we_q), .bank_val(bank_v_q),
    .low_we(low_we_q), .low_val(low_v_q),
    .inc_page(inc_page_q), .inc_full(inc_full_q),
    .ptr_q(ptr)
  );

  tw_state_e         state_q;
  logic [3:0]        bit_q;
  logic [7:0]        rx_q, tx_q;
  logic              rw_q, oe_q, wv_q, commit_q, wrote_q, rde_q, rde_d_q;
  logic [ADDR_W-1:0] wa_q, rda_q;
  logic [7:0]        wd_q;
  logic              active;
  logic              code_ok;

  assign active  = (state_q == ST_CTRL) || (state_q == ST_WADDR) ||
                   (state_q == ST_WDATA) || (state_q == ST_RDATA);
  assign code_ok = (rx_q[7:4] == CTRL_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      bit_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      rw_q       <= 1'b0;
      oe_q       <= 1'b0;
      wv_q       <= 1'b0;
      wa_q       <= '0;
      wd_q       <= '0;
      commit_q   <= 1'b0;
      wrote_q    <= 1'b0;
      rde_q      <= 1'b0;
      rde_d_q    <= 1'b0;
      rda_q      <= '0;
      bank_we_q  <= 1'b0;
      bank_v_q   <= '0;
      low_we_q   <= 1'b0;
      low_v_q    <= '0;
      inc_page_q <= 1'b0;
      inc_full_q <= 1'b0;
    end else begin
      commit_q   <= 1'b0;
      rde_q      <= 1'b0;
      bank_we_q  <= 1'b0;
      low_we_q   <= 1'b0;
      inc_page_q <= 1'b0;
      inc_full_q <= 1'b0;
      rde_d_q    <= rde_q;
      if (rde_d_q) tx_q <= rd_data;
      if (wv_q && wr_ready) wv_q <= 1'b0;

      if (stop_det) begin
        state_q  <= ST_IDLE;
        oe_q     <= 1'b0;
        bit_q    <= '0;
        commit_q <= wrote_q;
        wrote_q  <= 1'b0;
      end else if (start_det) begin
        state_q <= ST_CTRL;
        oe_q    <= 1'b0;
        bit_q   <= '0;
        wrote_q <= 1'b0;
      end else if (scl_rise && active) begin
        if (bit_q < ACK_BIT) begin
          bit_q <= bit_q + 1'b1;
          if (state_q != ST_RDATA) rx_q <= {rx_q[6:0], sda_s};
        end else if (bit_q == ACK_BIT) begin
          bit_q <= END_BIT;
          if (state_q == ST_RDATA) begin
            if (!sda_s) begin
              rde_q      <= 1'b1;
              rda_q      <= ptr;
              inc_full_q <= 1'b1;
            end else begin
              state_q <= ST_DROP;
            end
          end
        end
      end else if (scl_fall && active) begin
        if (bit_q == ACK_BIT) begin
          case (state_q)
            ST_CTRL: begin
              if (code_ok && !busy_i) begin
                oe_q      <= 1'b1;
                rw_q      <= rx_q[0];
                bank_we_q <= 1'b1;
                bank_v_q  <= rx_q[3:1];
                if (rx_q[0]) begin
                  rde_q      <= 1'b1;
                  rda_q      <= {rx_q[3:1], ptr[LOW_W-1:0]};
                  inc_full_q <= 1'b1;
                end
              end else begin
                state_q <= ST_DROP;
              end
            end
            ST_WADDR: begin
              if (!busy_i) begin
                oe_q     <= 1'b1;
                low_we_q <= 1'b1;
                low_v_q  <= rx_q[LOW_W-1:0];
              end else begin
                state_q <= ST_DROP;
              end
            end
            ST_WDATA: begin
              if (!busy_i && !(wv_q && !wr_ready)) begin
                oe_q       <= 1'b1;
                wv_q       <= 1'b1;
                wa_q       <= ptr;
                wd_q       <= rx_q;
                inc_page_q <= 1'b1;
                wrote_q    <= 1'b1;
              end else begin
                state_q <= ST_DROP;
              end
            end
            default: oe_q <= 1'b0;
          endcase
        end else if (bit_q == END_BIT) begin
          bit_q <= '0;
          oe_q  <= 1'b0;
          case (state_q)
            ST_CTRL: begin
              if (rw_q) begin
                state_q <= ST_RDATA;
                oe_q    <= ~tx_q[7];
                tx_q    <= {tx_q[6:0], 1'b0};
              end else begin
                state_q <= ST_WADDR;
              end
            end
            ST_WADDR: state_q <= ST_WDATA;
            ST_RDATA: begin
              oe_q <= ~tx_q[7];
              tx_q <= {tx_q[6:0], 1'b0};
            end
            default: state_q <= state_q;
          endcase
        end else if (state_q == ST_RDATA && bit_q != '0) begin
          oe_q <= ~tx_q[7];
          tx_q <= {tx_q[6:0], 1'b0};
        end
      end
    end
  end

  assign sda_oe    = oe_q;
  assign wr_valid  = wv_q;
  assign wr_addr   = wa_q;
  assign wr_data   = wd_q;
  assign wr_commit = commit_q;
  assign rd_en     = rde_q;
  assign rd_addr   = rda_q;

  // R13
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_s || $past(start_det || stop_det));

  // R8
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wv_q && !wr_ready |=> wv_q && $stable(wa_q) && $stable(wd_q));

  // R7
  commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |=> !commit_q);

  // R3
  drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DROP) && $past(state_q == ST_DROP) |-> !oe_q);
endmodule

// File: tb/sim_tw_mem_slave.sv
module sim_tw_mem_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;
  localparam logic [18:0] VEC [8] = '{
    {11'h000, 8'h5A}, {11'h7FF, 8'hC3}, {11'h123, 8'h01}, {11'h2A4, 8'hFE},
    {11'h355, 8'h80}, {11'h4C6, 8'h7E}, {11'h5A3, 8'hAA}, {11'h6F8, 8'h33}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic busy_i = 1'b0, wr_ready = 1'b1;
  logic sda_oe, wr_valid, wr_commit, rd_en;
  logic [10:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  wire sda_bus = m_sda & ~sda_oe;

  logic [7:0] mem [2048];
  logic [7:0] exp_mem [2048];
  int beats = 0, commits = 0, oe_viol = 0;
  logic [10:0] last_ba;
  logic [7:0] last_bd;
  int total = 0, fails = 0;
  bit done = 1'b0;
  logic prev_oe = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_mem_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .busy_i(busy_i), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_commit(wr_commit), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  initial begin
    for (int i = 0; i < 2048; i++) begin
      mem[i] = 8'(i) ^ 8'(i >> 3);
      exp_mem[i] = 8'(i) ^ 8'(i >> 3);
    end
  end

  always @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
    if (wr_valid && wr_ready) begin
      mem[wr_addr] <= wr_data;
      beats <= beats + 1;
      last_ba <= wr_addr;
      last_bd <= wr_data;
    end
    if (wr_commit) commits <= commits + 1;
  end

  always @(negedge clk) begin
    if (rst_n && sda_oe != prev_oe && m_scl) oe_viol <= oe_viol + 1;
    prev_oe <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic clk_bit(input logic drv, output logic smp);
    m_sda = drv; tick(Q);
    m_scl = 1'b1; tick(Q);
    smp = sda_bus; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, ack);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(mack, s);
  endtask

  function automatic logic [7:0] ctl(input logic [10:0] a, input logic rd);
    return {4'b1010, a[10:8], rd};
  endfunction

  task automatic set_addr(input logic [10:0] a, output logic nk);
    logic k1, k2;
    bus_start();
    send_byte(ctl(a, 1'b0), k1);
    send_byte(a[7:0], k2);
    nk = k1 | k2;
  endtask

  task automatic rand_read(input logic [10:0] a, output logic [7:0] d, output logic nk);
    logic k1, k2;
    set_addr(a, k1);
    bus_start();
    send_byte(ctl(a, 1'b1), k2);
    recv_byte(1'b1, d);
    bus_stop();
    nk = k1 | k2;
  endtask

  initial begin
    logic nk, k1, k2, k3, s;
    logic [7:0] d;
    logic [10:0] a;
    logic [7:0] v;
    int b0, c0;
    tick(5);
    // R1 reset state
    chk(!sda_oe && !wr_valid && !wr_commit && !rd_en, "R1 reset outputs",
        {sda_oe, wr_valid, wr_commit, rd_en}, 0);
    rst_n = 1'b1;
    tick(5);

    // vector table: byte write then random read (R2 R5 R7 R9)
    for (int i = 0; i < 8; i++) begin
      a = VEC[i][18:8];
      v = VEC[i][7:0];
      c0 = commits;
      set_addr(a, nk);
      send_byte(v, k3);
      bus_stop();
      tick(4);
      exp_mem[a] = v;
      chk(!nk && !k3, "R2 R5 write acks", {nk, k3}, 0);
      chk(last_ba == a && last_bd == v, "R5 beat address/data", {last_ba, last_bd}, {a, v});
      chk(commits == c0 + 1, "R7 commit once", commits - c0, 1);
      rand_read(a, d, nk);
      chk(!nk && d == exp_mem[a], "R9 random read", d, exp_mem[a]);
    end

    // R10 current-address read after read of 0x6F8
    bus_start();
    send_byte(ctl(11'h6F9, 1'b1), k1);
    recv_byte(1'b1, d);
    bus_stop();
    chk(!k1 && d == exp_mem[11'h6F9], "R10 current read", d, exp_mem[11'h6F9]);

    // R11 sequential read with wrap
    set_addr(11'h7FE, nk);
    bus_start();
    send_byte(ctl(11'h7FE, 1'b1), k1);
    for (int j = 0; j < 4; j++) begin
      recv_byte(j == 3, d);
      chk(d == exp_mem[11'(11'h7FE + j)], "R11 sequential wrap", d, exp_mem[11'(11'h7FE + j)]);
    end
    bus_stop();

    // R6 page wrap on write
    set_addr(11'h0FE, nk);
    send_byte(8'h11, k1);
    send_byte(8'h22, k2);
    send_byte(8'h33, k3);
    bus_stop();
    tick(4);
    exp_mem[11'h0FE] = 8'h11; exp_mem[11'h0FF] = 8'h22; exp_mem[11'h0F0] = 8'h33;
    chk(!k1 && !k2 && !k3 && last_ba == 11'h0F0, "R6 page wrap address", last_ba, 11'h0F0);
    rand_read(11'h0F0, d, nk);
    chk(d == 8'h33, "R6 wrapped byte", d, 8'h33);
    rand_read(11'h100, d, nk);
    chk(d == exp_mem[11'h100], "R6 next page untouched", d, exp_mem[11'h100]);

    // R7 address-only write gives no commit
    c0 = commits;
    set_addr(11'h010, nk);
    bus_stop();
    tick(4);
    chk(commits == c0, "R7 no commit without data", commits - c0, 0);

    // R3 wrong control code
    b0 = beats; c0 = commits;
    bus_start();
    send_byte(8'hB0, k1);
    send_byte(8'h40, k2);
    send_byte(8'h99, k3);
    bus_stop();
    tick(4);
    chk(k1 && k2 && k3, "R3 no ack on bad code", {k1, k2, k3}, 3'b111);
    chk(beats == b0 && commits == c0, "R3 nothing offered", beats - b0, 0);

    // R4 busy: polling
    busy_i = 1'b1;
    bus_start();
    send_byte(ctl(11'h000, 1'b0), k1);
    bus_stop();
    chk(k1, "R4 no ack while busy", k1, 1);
    busy_i = 1'b0;
    bus_start();
    send_byte(ctl(11'h000, 1'b0), k2);
    bus_stop();
    chk(!k2, "R4 ack after busy", k2, 0);

    // R8 back-pressure, STOP while beat pending
    wr_ready = 1'b0;
    b0 = beats; c0 = commits;
    set_addr(11'h230, nk);
    send_byte(8'hD0, k1);
    send_byte(8'hD1, k2);
    bus_stop();
    tick(4);
    chk(!k1 && k2, "R8 second byte nacked", {k1, k2}, 2'b01);
    chk(wr_valid && wr_addr == 11'h230 && wr_data == 8'hD0, "R8 beat held",
        {wr_valid, wr_addr, wr_data}, {1'b1, 11'h230, 8'hD0});
    chk(commits == c0 + 1, "R8 R7 single commit", commits - c0, 1);
    wr_ready = 1'b1;
    tick(3);
    exp_mem[11'h230] = 8'hD0;
    chk(beats == b0 + 1 && last_bd == 8'hD0, "R8 one beat accepted", beats - b0, 1);
    rand_read(11'h231, d, nk);
    chk(d == exp_mem[11'h231], "R8 dropped byte not written", d, exp_mem[11'h231]);

    // R12 master NACK releases SDA
    set_addr(11'h230, nk);
    bus_start();
    send_byte(ctl(11'h230, 1'b1), k1);
    recv_byte(1'b1, d);
    recv_byte(1'b1, v);
    bus_stop();
    chk(d == 8'hD0 && v == 8'hFF, "R12 released after nack", v, 8'hFF);

    // R13 output edge placement
    chk(oe_viol == 0, "R13 sda_oe changes with SCL low", oe_viol, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule